// File: doc/BRIEF.md
# Accelerator Instruction Sequencer

This block steps through a short program of 16-bit instructions held in its own 16-entry instruction store. It decodes each word in turn and either updates a base-address register or starts one of four datapath units: weight loading, input loading, the systolic computation, or write-back of results. After it starts a unit, it waits for that unit to report completion before it moves to the next instruction. The base-address register is driven continuously to the units.

The top three bits of each word select the operation, and the low thirteen bits carry an address value. A program ends at an end word, at an illegal operation, or after its last store entry. Software loads the instruction store through a valid/ready write channel and then pulses a start input. The write channel applies back-pressure for the whole run. `prog_ready` is low while a program is executing. A write presented while ready is low is not stored, and the writer must hold or retry it. Start and status are plain level/pulse pins.

Top module: `accel_seq`

## Requirements
- R1: Instruction bits [15:13] select the operation and bits [12:0] are the immediate. Operation 001 copies the immediate into the base-address register in one cycle with no handshake. `base_addr` shows the register at all times. The register keeps its value across runs and changes only on another 001.
- R2: Operations 010, 011, 100 and 101 raise `unit_go[0]`, `unit_go[1]`, `unit_go[2]` and `unit_go[3]` respectively (weights, inputs, compute, store). Each raise lasts exactly one cycle, and at most one bit is high at a time.
- R3: After a pulse on `unit_go[k]`, the sequencer stays on that instruction until `unit_done[k]` is high on a cycle after the pulse. A done from any other unit has no effect.
- R4: Operation 000 stops execution. `finished` is set, `busy` clears and no pulse is issued.
- R5: Operations 110 and 111 stop execution. `fault` is set, `finished` stays low and no pulse is issued.
- R6: Instructions run in order from entry 0 upward. If entry 15 completes without an end word, execution stops with `finished` set.
- R7: `start` is accepted only while the sequencer is not busy. It clears `finished` and `fault` and begins at entry 0. A `start` pulse while busy is ignored.
- R8: `prog_ready` equals not-busy. A write happens only when `prog_valid` and `prog_ready` are both high, and it stores `prog_data` at entry `prog_addr`. A write in the same cycle as an accepted `start` is visible to that run.
- R9: After reset the sequencer is idle, with no flags set, `base_addr` at zero, no pulses, and all entries holding the end word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_valid | input | 1 | Instruction write request |
| prog_ready | output | 1 | Store can accept a write (not busy) |
| prog_addr | input | 4 | Instruction entry to write |
| prog_data | input | 16 | Instruction word to write |
| start | input | 1 | Begin execution at entry 0 |
| unit_done | input | 4 | Completion from each datapath unit |
| unit_go | output | 4 | One-cycle start pulse to each datapath unit |
| base_addr | output | 13 | Current base-address register |
| busy | output | 1 | Program executing |
| finished | output | 1 | Program ended normally |
| fault | output | 1 | Program stopped on an illegal operation |

## Verification
Two functions can fall in the same cycle. A program write and an accepted start can coincide, and the bench provokes this by writing entry 0 in the very cycle it pulses start. It judges the result by checking that the first pulse on the scoreboard belongs to the newly written word and carries the base address left over from the previous run. A second collision puts a write, a start and a foreign done in the same cycles as a unit wait. In that case the scoreboard must still see the original program order, the pulse count must stay frozen, and `prog_ready` must stay low.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int INSTR_W = 16;
  localparam int OP_W    = 3;
  localparam int IMM_W   = INSTR_W - OP_W;
  localparam int N_UNITS = 4;
  localparam int UNIT_W  = $clog2(N_UNITS);

  localparam logic [OP_W-1:0] OP_END  = 3'b000;
  localparam logic [OP_W-1:0] OP_BASE = 3'b001;
  localparam logic [OP_W-1:0] OP_WGT  = 3'b010;
  localparam logic [OP_W-1:0] OP_STO  = 3'b101;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_PULSE, ST_WAIT, ST_FIN, ST_ERR
  } seq_state_e;
endpackage

// File: rtl/seq_imem.sv
module seq_imem #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/seq_issue.sv
module seq_issue
  import seq_pkg::*;
#(
  parameter int NU = N_UNITS,
  localparam int UW = $clog2(NU)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse,
  input  logic [UW-1:0] unit_sel,
  input  logic [NU-1:0] done_vec,
  output logic [NU-1:0] go_vec,
  output logic          sel_done
);
  for (genvar g = 0; g < NU; g++) begin : g_go
    assign go_vec[g] = pulse && (unit_sel == UW'(g));
  end

  assign sel_done = done_vec[unit_sel];

  // R2: never two units started at once
  p_go_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(go_vec));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  input  logic               sel_done,
  output logic [AW-1:0]      pc,
  output logic [IMM_W-1:0]   base_q,
  output logic [UNIT_W-1:0]  unit_q,
  output logic               pulse,
  output logic               busy,
  output logic               fin,
  output logic               err
);
  seq_state_e st_q;
  logic [OP_W-1:0]  op;
  logic [IMM_W-1:0] imm;
  logic             last;

  assign op   = instr[INSTR_W-1 -: OP_W];
  assign imm  = instr[IMM_W-1:0];
  assign last = (pc == AW'(DEPTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pc     <= '0;
      base_q <= '0;
      unit_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_FIN, ST_ERR: begin
          if (start) begin
            pc   <= '0;
            st_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (op == OP_BASE) begin
            base_q <= imm;
            if (last) st_q <= ST_FIN;
            else      pc <= pc + 1'b1;
          end else if (op == OP_END) begin
            st_q <= ST_FIN;
          end else if (op >= OP_WGT && op <= OP_STO) begin
            unit_q <= UNIT_W'(op - OP_WGT);
            st_q   <= ST_PULSE;
          end else begin
            st_q <= ST_ERR;
          end
        end
        ST_PULSE: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (sel_done) begin
            if (last) st_q <= ST_FIN;
            else begin
              pc   <= pc + 1'b1;
              st_q <= ST_RUN;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pulse = (st_q == ST_PULSE);
  assign busy  = (st_q == ST_RUN) || (st_q == ST_PULSE) || (st_q == ST_WAIT);
  assign fin   = (st_q == ST_FIN);
  assign err   = (st_q == ST_ERR);

  // R4/R5: the two stop flags exclude each other
  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fin && err));
  // R5: a fault holds until a new start
  p_fault_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);
  // R1: base register frozen while not executing
  p_base_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(base_q));
  // R3: a waiting instruction holds the program counter without its done
  p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !sel_done) |=> (st_q == ST_WAIT && $stable(pc)));
endmodule

// File: rtl/accel_seq.sv
module accel_seq
  import seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prog_valid,
  output logic                prog_ready,
  input  logic [AW-1:0]       prog_addr,
  input  logic [INSTR_W-1:0]  prog_data,
  input  logic                start,
  input  logic [N_UNITS-1:0]  unit_done,
  output logic [N_UNITS-1:0]  unit_go,
  output logic [IMM_W-1:0]    base_addr,
  output logic                busy,
  output logic                finished,
  output logic                fault
);
  logic [AW-1:0]      pc;
  logic [INSTR_W-1:0] instr;
  logic [UNIT_W-1:0]  unit_sel;
  logic               pulse, sel_done;

  assign prog_ready = !busy;

  seq_imem #(.DEPTH(DEPTH), .WIDTH(INSTR_W)) u_imem (
    .clk, .rst_n,
    .wr_en  (prog_valid && prog_ready),
    .wr_addr(prog_addr),
    .wr_data(prog_data),
    .rd_addr(pc),
    .rd_data(instr)
  );

  seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rst_n, .start, .instr, .sel_done,
    .pc, .base_q(base_addr), .unit_q(unit_sel), .pulse,
    .busy, .fin(finished), .err(fault)
  );

  seq_issue #(.NU(N_UNITS)) u_issue (
    .clk, .rst_n, .pulse, .unit_sel,
    .done_vec(unit_done), .go_vec(unit_go), .sel_done
  );

  // R2: every start pulse is exactly one cycle long
  p_go_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_go) |=> (unit_go == '0));
  // R7: no unit is started outside a run
  p_no_go_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (unit_go == '0));
  // R8: the write channel is closed while executing
  p_ready_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_go) |-> !prog_ready);
endmodule

// File: tb/accel_seq_tb_top.sv
module accel_seq_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        prog_valid = 0;
  logic        prog_ready;
  logic [3:0]  prog_addr = '0;
  logic [15:0] prog_data = '0;
  logic        start = 0;
  logic [3:0]  unit_done;
  logic [3:0]  unit_go;
  logic [12:0] base_addr;
  logic        busy, finished, fault;

  logic [3:0]  resp_done = '0;
  logic [3:0]  spur_done = '0;
  int          lat [4] = '{2, 3, 5, 1};
  int          errors = 0, checks = 0, go_cnt = 0;
  int          exp_unit_q [$];
  int          exp_addr_q [$];

  assign unit_done = resp_done | spur_done;

  always #5 clk = ~clk;

  accel_seq dut_i (
    .clk, .rst_n, .prog_valid, .prog_ready, .prog_addr, .prog_data,
    .start, .unit_done, .unit_go, .base_addr, .busy, .finished, .fault
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input int op, input int imm);
    return {3'(op), 13'(imm)};
  endfunction

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    prog_valid = 1; prog_addr = 4'(a); prog_data = d;
    @(negedge clk);
    prog_valid = 0;
  endtask

  task automatic expect_go(input int u, input int a);
    exp_unit_q.push_back(u);
    exp_addr_q.push_back(a);
  endtask

  task automatic kick();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    chk(!busy, tag, busy, 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && unit_go != 0) begin
      int u;
      go_cnt++;
      u = (unit_go == 4'b0001) ? 0 : (unit_go == 4'b0010) ? 1 :
          (unit_go == 4'b0100) ? 2 : (unit_go == 4'b1000) ? 3 : 9;
      chk(!prog_ready, "R8 ready low during run", prog_ready, 0);
      if (exp_unit_q.size() == 0) begin
        chk(0, "R2 unexpected pulse", u, 0);
      end else begin
        int eu, ea;
        eu = exp_unit_q.pop_front();
        ea = exp_addr_q.pop_front();
        chk(u == eu, "R2 unit order", u, eu);
        chk(int'(base_addr) == ea, "R1 base addr at pulse", base_addr, ea);
      end
    end
  end

  // datapath responders
  for (genvar g = 0; g < 4; g++) begin : g_resp
    initial begin
      forever begin
        @(negedge clk);
        if (unit_go[g]) begin
          @(negedge clk);
          chk(unit_go[g] == 0, "R2 pulse one cycle", unit_go[g], 0);
          repeat (lat[g] - 1) @(negedge clk);
          resp_done[g] = 1;
          @(negedge clk);
          resp_done[g] = 0;
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(!busy && !finished && !fault, "R9 idle flags", {busy, finished, fault}, 0);
    chk(base_addr == 0, "R9 base addr", base_addr, 0);
    chk(unit_go == 0, "R9 no pulse", unit_go, 0);
    chk(prog_ready, "R9 ready", prog_ready, 1);
    kick();
    wait_idle("R9 empty store runs end");
    chk(finished && !fault, "R9 store reset to end word", {finished, fault}, 2'b10);

    // Test A: reference program, R1 R2 R3 R4 R6
    wr(0, ins(1, 'h0F)); wr(1, ins(2, 0)); wr(2, ins(1, 'h1E));
    wr(3, ins(3, 0));    wr(4, ins(4, 0)); wr(5, ins(1, 'h07));
    wr(6, ins(5, 0));    wr(7, ins(0, 0));
    expect_go(0, 'h0F); expect_go(1, 'h1E); expect_go(2, 'h1E); expect_go(3, 'h07);
    kick();
    chk(busy && !finished, "R7 start accepted", busy, 1);
    wait_idle("R4 program ends");
    chk(finished && !fault, "R4 finished flag", {finished, fault}, 2'b10);
    chk(exp_unit_q.size() == 0, "R6 all pulses issued", exp_unit_q.size(), 0);
    chk(base_addr == 'h07, "R1 base holds", base_addr, 'h07);

    // Test B: write and start in same cycle, R8 R7 R1
    expect_go(3, 'h07); expect_go(0, 'h07); expect_go(1, 'h1E);
    expect_go(2, 'h1E); expect_go(3, 'h07);
    @(negedge clk);
    prog_valid = 1; prog_addr = 0; prog_data = ins(5, 0); start = 1;
    @(negedge clk);
    prog_valid = 0; start = 0;
    wait_idle("R8 same-cycle run ends");
    chk(exp_unit_q.size() == 0, "R8 same-cycle write seen", exp_unit_q.size(), 0);
    chk(finished, "R7 finished again", finished, 1);

    // Test C: illegal opcodes, R5
    for (int op = 6; op <= 7; op++) begin
      wr(0, ins(1, 5 + op)); wr(1, ins(op, 0)); wr(2, ins(2, 0));
      kick();
      wait_idle("R5 stops");
      chk(fault && !finished, "R5 fault flag", {fault, finished}, 2'b10);
      chk(int'(base_addr) == 5 + op, "R5 prior base kept", base_addr, 5 + op);
    end
    chk(go_cnt == 9, "R5 no pulse on illegal", go_cnt, 9);

    // Test D: busy-time collisions, R3 R7 R8
    lat[0] = 30;
    wr(0, ins(2, 0)); wr(1, ins(3, 0)); wr(2, ins(0, 0));
    expect_go(0, 12); expect_go(1, 12);
    kick();
    chk(!fault, "R7 start clears fault", fault, 0);
    repeat (4) @(negedge clk);
    prog_valid = 1; prog_addr = 1; prog_data = ins(5, 0); start = 1;
    spur_done = 4'b1110;
    repeat (3) @(negedge clk);
    prog_valid = 0; start = 0; spur_done = 0;
    repeat (4) @(negedge clk);
    chk(go_cnt == 10, "R3 foreign done ignored", go_cnt, 10);
    chk(busy && !prog_ready, "R8 ready low while busy", prog_ready, 0);
    wait_idle("R3 run resumes");
    chk(exp_unit_q.size() == 0, "R7 start and write ignored while busy", exp_unit_q.size(), 0);
    lat[0] = 2;

    // Test E: no end word, runs off last entry, R6
    for (int i = 0; i < 15; i++) wr(i, ins(1, 100 + i));
    wr(15, ins(4, 0));
    expect_go(2, 114);
    kick();
    wait_idle("R6 last entry");
    chk(finished && !fault, "R6 stop after entry 15", {finished, fault}, 2'b10);
    chk(exp_unit_q.size() == 0, "R6 last pulse", exp_unit_q.size(), 0);
    chk(base_addr == 114, "R1 last base", base_addr, 114);

    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule